// File: doc/BRIEF.md
# Board Control Register Block

This block is a small set of memory-mapped board-control registers behind a simple 32-bit register bus. The bus carries an address, a write enable with write data, and a read enable. Read data comes back one cycle after the read strobe. Software uses the block for four things:

- to identify the hardware build, through a fixed 32-bit code;
- to learn the processor clock rate, which is set by a parameter;
- to drive a bank of LEDs;
- to sample a bank of DIP switches.

A dedicated control word lets software ask for a board-wide reset. Writing one specific magic value to it raises a single-cycle reset request towards the system reset controller. Any other value written there is dropped.

The block decodes a 64 KiB window. Only five word offsets inside it mean anything. Every other offset reads as zero and ignores writes. The switch inputs are asynchronous to the bus clock. They pass through a two-flop synchronizer and a capture register before a read can return them.

Top module: `board_ctl_regs`

## Requirements
- R1: While reset is active and in the first cycle after it, `ledOut`, `busRdata` and `sysRstReq` are all zero.
- R2: A read of offset 0x0000 returns 0x09272011. A write to that offset changes nothing observable.
- R3: A read of offset 0x0004 returns the parameter `CLK_FREQ_HZ`, which defaults to 10,000,000. Writes to that offset change nothing.
- R4: A write to offset 0x0008 stores `busWdata[LED_W-1:0]`, and the stored value drives `ledOut` from the next cycle. A read of 0x0008 returns the stored value zero-extended to 32 bits, where 1 means the LED is lit.
- R5: A read of offset 0x000C returns the switch inputs zero-extended, where 1 means on. After `swIn` changes, reads issued in the next three cycles return the old value, and the read issued in the fourth cycle returns the new value. Writes to 0x000C change nothing.
- R6: A write of exactly 0x0000DEAD to offset 0x0010 raises `sysRstReq` for exactly one cycle, in the cycle after the write. `sysRstReq` is never high two cycles in a row, even when magic writes come back to back.
- R7: A write of any other value to offset 0x0010 leaves `sysRstReq` low.
- R8: A read of any offset other than 0x0, 0x4, 0x8 or 0xC returns zero. This includes 0x0010, unaligned offsets and offsets higher in the window. A write to any of those offsets leaves the LED register unchanged.
- R9: `busRdata` carries the read result in the cycle after `busRe`, and is zero in any cycle that follows a cycle without `busRe`. Reads change no state.
- R10: When a read and a write of 0x0008 happen in the same cycle, the read returns the value held before the write.

Note: addresses are byte offsets on a 16-bit `busAddr` and must match exactly. Only full 32-bit accesses exist.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W (16) | Byte offset inside the 64 KiB window |
| busWe | input | 1 | Write strobe, one access per cycle |
| busWdata | input | DATA_W (32) | Write data |
| busRe | input | 1 | Read strobe |
| busRdata | output | DATA_W (32) | Registered read data, valid the cycle after `busRe` |
| swIn | input | SW_W (8) | Raw DIP-switch levels, asynchronous |
| ledOut | output | LED_W (8) | LED drive, 1 = lit |
| sysRstReq | output | 1 | Single-cycle system reset request |

## Verification
A corrupted LED register shows at once on `ledOut`, one cycle after the write that should have set it. A readback of 0x0008 exposes it on `busRdata` one cycle later.

A wrong decode of the reset-control word shows as either a missing or a stray `sysRstReq` pulse in the cycle right after the write. A pulse that lasts too long shows in the cycle after that.

A synchronizer chain of the wrong length shows only through a read of 0x000C. That read returns the new switch value one cycle too early or too late, so the bench tests the exact latency edge.

// File: rtl/board_ctl_pkg.sv
package board_ctl_pkg;

  // Word offsets decoded inside the window
  localparam logic [15:0] OFS_BUILD = 16'h0000;
  localparam logic [15:0] OFS_FREQ  = 16'h0004;
  localparam logic [15:0] OFS_LED   = 16'h0008;
  localparam logic [15:0] OFS_SW    = 16'h000C;
  localparam logic [15:0] OFS_RST   = 16'h0010;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_BUILD,
    SEL_FREQ,
    SEL_LED,
    SEL_SW
  } regSel_e;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic    ledWr;
    logic    rdEn;
    regSel_e rdSel;
  } ctlStrobe_t;

endpackage

// File: rtl/board_ctl_ctrl.sv
module board_ctl_ctrl
  import board_ctl_pkg::*;
#(
  parameter int          ADDR_W = 16,
  parameter int          DATA_W = 32,
  parameter logic [31:0] MAGIC  = 32'h0000_DEAD
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busRe,
  output ctlStrobe_t        strobe,
  output logic              sysRstReq
);

  localparam logic [DATA_W-1:0] MagicWord = DATA_W'(MAGIC);

  regSel_e readSel;
  logic    hitLed;
  logic    hitRst;
  logic    rstKick;

  // Exact-match decode of the read target
  always_comb begin
    unique case (busAddr)
      ADDR_W'(OFS_BUILD): readSel = SEL_BUILD;
      ADDR_W'(OFS_FREQ):  readSel = SEL_FREQ;
      ADDR_W'(OFS_LED):   readSel = SEL_LED;
      ADDR_W'(OFS_SW):    readSel = SEL_SW;
      default:            readSel = SEL_NONE;
    endcase
  end

  assign hitLed  = (busAddr == ADDR_W'(OFS_LED));
  assign hitRst  = (busAddr == ADDR_W'(OFS_RST));
  assign rstKick = busWe && hitRst && (busWdata == MagicWord);

  always_comb begin
    strobe.ledWr = busWe && hitLed;
    strobe.rdEn  = busRe;
    strobe.rdSel = readSel;
  end

  // Registered request; suppressed in the cycle after a pulse so it never widens
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sysRstReq <= 1'b0;
    end else begin
      sysRstReq <= rstKick && !sysRstReq;
    end
  end

endmodule

// File: rtl/board_ctl_dpath.sv
module board_ctl_dpath
  import board_ctl_pkg::*;
#(
  parameter int          DATA_W      = 32,
  parameter int          LED_W       = 8,
  parameter int          SW_W        = 8,
  parameter int          SYNC_STAGES = 2,
  parameter int unsigned CLK_FREQ_HZ = 10_000_000,
  parameter logic [31:0] BUILD_ID    = 32'h0927_2011
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [LED_W-1:0]  ledWdata,
  input  logic [SW_W-1:0]   swIn,
  output logic [LED_W-1:0]  ledOut,
  output logic [DATA_W-1:0] busRdata
);

  localparam logic [DATA_W-1:0] BuildWord = DATA_W'(BUILD_ID);
  localparam logic [DATA_W-1:0] FreqWord  = DATA_W'(CLK_FREQ_HZ);

  logic [LED_W-1:0]  ledReg;
  logic [SW_W-1:0]   swSync [SYNC_STAGES];
  logic [SW_W-1:0]   swReg;
  logic [DATA_W-1:0] rdNext;

  // LED storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ledReg <= '0;
    end else if (strobe.ledWr) begin
      ledReg <= ledWdata;
    end
  end

  assign ledOut = ledReg;

  // Switch synchronizer chain
  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) swSync[gi] <= '0;
          else       swSync[gi] <= swIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) swSync[gi] <= '0;
          else       swSync[gi] <= swSync[gi-1];
        end
      end
    end
  endgenerate

  // Capture register holding the readable switch value
  always_ff @(posedge clk) begin
    if (!rstN) swReg <= '0;
    else       swReg <= swSync[SYNC_STAGES-1];
  end

  // Read mux
  always_comb begin
    unique case (strobe.rdSel)
      SEL_BUILD: rdNext = BuildWord;
      SEL_FREQ:  rdNext = FreqWord;
      SEL_LED:   rdNext = DATA_W'(ledReg);
      SEL_SW:    rdNext = DATA_W'(swReg);
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdata <= '0;
    end else if (strobe.rdEn) begin
      busRdata <= rdNext;
    end else begin
      busRdata <= '0;
    end
  end

endmodule

// File: rtl/board_ctl_regs.sv
module board_ctl_regs
  import board_ctl_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int          DATA_W      = 32,
  parameter int          LED_W       = 8,
  parameter int          SW_W        = 8,
  parameter int          SYNC_STAGES = 2,
  parameter int unsigned CLK_FREQ_HZ = 10_000_000,
  parameter logic [31:0] BUILD_ID    = 32'h0927_2011,
  parameter logic [31:0] MAGIC       = 32'h0000_DEAD
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busRe,
  output logic [DATA_W-1:0] busRdata,
  input  logic [SW_W-1:0]   swIn,
  output logic [LED_W-1:0]  ledOut,
  output logic              sysRstReq
);

  ctlStrobe_t strobe;

  board_ctl_ctrl #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .MAGIC (MAGIC)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWe    (busWe),
    .busWdata (busWdata),
    .busRe    (busRe),
    .strobe   (strobe),
    .sysRstReq(sysRstReq)
  );

  board_ctl_dpath #(
    .DATA_W     (DATA_W),
    .LED_W      (LED_W),
    .SW_W       (SW_W),
    .SYNC_STAGES(SYNC_STAGES),
    .CLK_FREQ_HZ(CLK_FREQ_HZ),
    .BUILD_ID   (BUILD_ID)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .ledWdata(busWdata[LED_W-1:0]),
    .swIn    (swIn),
    .ledOut  (ledOut),
    .busRdata(busRdata)
  );

endmodule

// File: rtl/board_ctl_chk.sv
module board_ctl_chk #(
  parameter int          ADDR_W      = 16,
  parameter int          DATA_W      = 32,
  parameter int          LED_W       = 8,
  parameter int unsigned CLK_FREQ_HZ = 10_000_000,
  parameter logic [31:0] BUILD_ID    = 32'h0927_2011,
  parameter logic [31:0] MAGIC       = 32'h0000_DEAD
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic [DATA_W-1:0] busWdata,
  input logic              busRe,
  input logic [DATA_W-1:0] busRdata,
  input logic [LED_W-1:0]  ledOut,
  input logic              sysRstReq
);

  p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    sysRstReq |=> !sysRstReq);

  p_pulse_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    sysRstReq |-> $past(busWe && busAddr == ADDR_W'(16'h0010) && busWdata == DATA_W'(MAGIC)));

  p_led_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(busWe && busAddr == ADDR_W'(16'h0008)) |=> $stable(ledOut));

  p_read_old_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && busAddr == ADDR_W'(16'h0008)) |=> busRdata == DATA_W'($past(ledOut)));

  p_build_id_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && busAddr == ADDR_W'(16'h0000)) |=> busRdata == DATA_W'(BUILD_ID));

  p_freq_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && busAddr == ADDR_W'(16'h0004)) |=> busRdata == DATA_W'(CLK_FREQ_HZ));

  p_rst_ofs_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && busAddr == ADDR_W'(16'h0010)) |=> busRdata == '0);

  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    !busRe |=> busRdata == '0);

endmodule

bind board_ctl_regs board_ctl_chk #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .LED_W      (LED_W),
  .CLK_FREQ_HZ(CLK_FREQ_HZ),
  .BUILD_ID   (BUILD_ID),
  .MAGIC      (MAGIC)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWe    (busWe),
  .busWdata (busWdata),
  .busRe    (busRe),
  .busRdata (busRdata),
  .ledOut   (ledOut),
  .sysRstReq(sysRstReq)
);

// File: tb/board_ctl_regs_tb.sv
module board_ctl_regs_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LED_W = 8;
  localparam int SW_W  = 8;
  localparam logic [31:0] ID_WORD = 32'h0927_2011;
  localparam logic [31:0] FREQ_WORD = 32'd10_000_000;
  localparam logic [31:0] MAGIC_WORD = 32'h0000_DEAD;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic        busRe = 1'b0;
  logic [31:0] busRdata;
  logic [SW_W-1:0]  swIn = '0;
  logic [LED_W-1:0] ledOut;
  logic        sysRstReq;

  int errors = 0;
  int checks = 0;

  logic [LED_W-1:0] ledModel = '0;
  logic [SW_W-1:0]  swModel = '0;
  logic             pulseModel = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  board_ctl_regs u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRe(busRe), .busRdata(busRdata),
    .swIn(swIn), .ledOut(ledOut), .sysRstReq(sysRstReq)
  );

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(input logic [15:0] a);
    case (a)
      16'h0000: return ID_WORD;
      16'h0004: return FREQ_WORD;
      16'h0008: return 32'(ledModel);
      16'h000C: return 32'(swModel);
      default:  return 32'h0;
    endcase
  endfunction

  // One bus cycle: drive at negedge, check results at the following negedge
  task automatic doCycle(input string tag, input logic we, input logic re,
                         input logic [15:0] a, input logic [31:0] d);
    logic [31:0] expData;
    logic        expPulse;
    busWe = we; busRe = re; busAddr = a; busWdata = d;
    expData  = re ? expRead(a) : 32'h0;
    expPulse = we && (a == 16'h0010) && (d == MAGIC_WORD) && !pulseModel;
    if (we && a == 16'h0008) ledModel = d[LED_W-1:0];
    pulseModel = expPulse;
    @(posedge clk);
    @(negedge clk);
    busWe = 1'b0; busRe = 1'b0;
    checkEq({tag, " rdata"}, busRdata, expData);
    checkEq({tag, " led"}, 32'(ledOut), 32'(ledModel));
    checkEq({tag, " pulse"}, 32'(sysRstReq), 32'(expPulse));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: reset state
    checkEq("R1 led", 32'(ledOut), 32'h0);
    checkEq("R1 rdata", busRdata, 32'h0);
    checkEq("R1 pulse", 32'(sysRstReq), 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    checkEq("R1 after", {31'h0, sysRstReq} | busRdata | 32'(ledOut), 32'h0);

    // R2 / R3: constants, writes ignored
    doCycle("R2 read", 1'b0, 1'b1, 16'h0000, 0);
    doCycle("R2 write", 1'b1, 1'b0, 16'h0000, 32'hFFFF_FFFF);
    doCycle("R2 reread", 1'b0, 1'b1, 16'h0000, 0);
    doCycle("R3 write", 1'b1, 1'b0, 16'h0004, 32'h1234_5678);
    doCycle("R3 read", 1'b0, 1'b1, 16'h0004, 0);

    // R4: LED write and readback
    doCycle("R4 write", 1'b1, 1'b0, 16'h0008, 32'hABCD_EFA5);
    doCycle("R4 read", 1'b0, 1'b1, 16'h0008, 0);
    // R10: same-cycle read and write returns old value
    doCycle("R10 rw", 1'b1, 1'b1, 16'h0008, 32'h0000_003C);
    doCycle("R10 after", 1'b0, 1'b1, 16'h0008, 0);

    // R5: switch latency and write ignored
    swIn = 8'h5A;
    doCycle("R5 lat1", 1'b0, 1'b1, 16'h000C, 0);
    doCycle("R5 lat2", 1'b0, 1'b1, 16'h000C, 0);
    doCycle("R5 lat3", 1'b1, 1'b1, 16'h000C, 32'hFFFF_FFFF);
    swModel = 8'h5A;
    doCycle("R5 new", 1'b0, 1'b1, 16'h000C, 0);

    // R6 / R7: reset request
    doCycle("R7 wrong", 1'b1, 1'b0, 16'h0010, 32'h0001_DEAD);
    doCycle("R7 wrong2", 1'b1, 1'b0, 16'h0010, 32'h0000_DEAE);
    doCycle("R6 magic", 1'b1, 1'b0, 16'h0010, MAGIC_WORD);
    doCycle("R6 idle", 1'b0, 1'b0, 16'h0000, 0);
    doCycle("R6 b2b1", 1'b1, 1'b0, 16'h0010, MAGIC_WORD);
    doCycle("R6 b2b2", 1'b1, 1'b0, 16'h0010, MAGIC_WORD);
    doCycle("R6 b2b3", 1'b1, 1'b0, 16'h0010, MAGIC_WORD);
    doCycle("R6 magic other ofs", 1'b1, 1'b0, 16'h0014, MAGIC_WORD);

    // R8: undefined offsets
    doCycle("R8 rst ofs", 1'b0, 1'b1, 16'h0010, 0);
    doCycle("R8 unaligned", 1'b0, 1'b1, 16'h0009, 0);
    doCycle("R8 high", 1'b0, 1'b1, 16'hFFF8, 0);
    doCycle("R8 write", 1'b1, 1'b0, 16'h0108, 32'hFFFF_FFFF);
    doCycle("R8 check", 1'b0, 1'b1, 16'h0008, 0);

    // R9: idle cycle gives zero, reads do not disturb
    doCycle("R9 idle", 1'b0, 1'b0, 16'h0008, 0);
    doCycle("R9 read", 1'b0, 1'b1, 16'h0008, 0);

    // Random mix (R4 R6 R7 R8 R9)
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      logic [31:0] d;
      int pick;
      pick = int'($urandom % 7);
      case (pick)
        0: a = 16'h0000;
        1: a = 16'h0004;
        2: a = 16'h0008;
        3: a = 16'h000C;
        4: a = 16'h0010;
        5: a = 16'h0014;
        default: a = 16'($urandom);
      endcase
      d = $urandom;
      if (a == 16'h0010 && ($urandom % 2) == 0) d = MAGIC_WORD;
      doCycle("R9 random", 1'($urandom), 1'($urandom), a, d);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule